// File: doc/BRIEF.md
# Coin Vending Controller

This controller counts coins from a single sensor that reports nickels (5 cents) and dimes (10 cents). When the deposited credit reaches 15 cents or more, it raises a release signal that lets one item drop. No change is returned. The credit is one of four levels: 0, 5, 10 or 15 cents. The top level is full, and it holds there until the system resets it.

Two elaboration parameters select the implementation. `ENC` picks binary (two state flops) or one-hot (four state flops) for the credit register. `REG_OPEN` picks how the release output is formed:

- In the decoded form, release is decoded from the state register.
- In the retimed form, release is computed one step ahead from the next-state logic and stored in its own flip-flop, so the pin is driven straight from a register.

All four builds produce the same output sequence, cycle for cycle.

Top module: `coin_vend_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the credit becomes 0 cents and `release_o` is low from that edge on (synchronous reset).
- R2: A nickel pulse at 0 cents moves the credit to 5 cents, and `release_o` stays low.
- R3: A dime pulse at 0 cents moves the credit to 10 cents, and `release_o` stays low.
- R4: At 5 cents, a nickel moves the credit to 10 cents (no release) and a dime moves it to 15 cents (release).
- R5: At 10 cents, either coin moves the credit to 15 cents and asserts `release_o`.
- R6: In a cycle with no coin pulse, the credit is unchanged.
- R7: Once `release_o` is high, it stays high and further coins have no effect until `rst`.
- R8: A nickel and a dime in the same cycle count as a single dime.
- R9: `release_o` rises in the cycle right after the edge that captures the completing coin. This timing is identical for binary and one-hot encoding, and for both the decoded and retimed output forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse per 5-cent coin |
| dime_i | input | 1 | One-cycle pulse per 10-cent coin |
| release_o | output | 1 | High while the credit is 15 cents; opens the chute |

## Verification
All four parameter builds run side by side on the same stimulus.

- A retimed output that took its value from the current state rather than the next one would lag the decoded builds by a cycle. The bench would catch this as a one-cycle mismatch at every purchase.
- The bench targets simultaneous coin pulses. A build that added the nickel as well, or that took the one-hot path into two states at once, would jump straight from 0 to full on the first such pulse.
- Coins arriving at full credit check that the machine never wraps past 15 cents back toward a lower level.
- Resets arriving mid-purchase check that credit never survives a reset.

// File: rtl/vend_pkg.sv
package vend_pkg;

   // Credit levels in 5-cent units; the binary state register uses this code directly.
   typedef enum logic [1:0] {
      CR_0  = 2'd0,
      CR_5  = 2'd1,
      CR_10 = 2'd2,
      CR_15 = 2'd3
   } credit_e;

   // State register encoding choice.
   typedef enum logic {
      ENC_BINARY = 1'b0,
      ENC_ONEHOT = 1'b1
   } enc_e;

   // Qualified coin event: at most one field set.
   typedef struct packed {
      logic nickel;
      logic dime;
   } coin_s;

   localparam int LEVELS      = 4;
   localparam int BIN_BITS    = $clog2(LEVELS);
   localparam int ONEHOT_BITS = LEVELS;

endpackage

// File: rtl/vend_coin_qual.sv
module vend_coin_qual
   import vend_pkg::*;
(
   input  logic  nickel_raw,
   input  logic  dime_raw,
   output coin_s coin
);

   // A simultaneous pair counts as a dime only.
   always_comb begin
      coin.dime   = dime_raw;
      coin.nickel = nickel_raw & ~dime_raw;
   end

endmodule

// File: rtl/vend_state_bin.sv
module vend_state_bin
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  coin_s   coin,
   output credit_e credit,
   output logic    full_now,
   output logic    full_next
);

   logic [BIN_BITS-1:0] q;
   logic [BIN_BITS-1:0] d;

   // Sum-of-products next state for the two credit bits.
   always_comb begin
      d[1] = q[1] | coin.dime | (q[0] & coin.nickel);
      d[0] = (~q[0] & coin.nickel) | (q[0] & ~coin.nickel)
           | (q[1] & coin.nickel)  | (q[1] & coin.dime);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   assign credit    = credit_e'(q);
   assign full_now  = q[1] & q[0];
   assign full_next = ~rst & d[1] & d[0];

endmodule

// File: rtl/vend_state_onehot.sv
module vend_state_onehot
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  coin_s   coin,
   output credit_e credit,
   output logic    full_now,
   output logic    full_next
);

   localparam logic [ONEHOT_BITS-1:0] IDLE_HOT = ONEHOT_BITS'(1);

   logic [ONEHOT_BITS-1:0] q;
   logic [ONEHOT_BITS-1:0] nx;
   logic                   no_coin;

   assign no_coin = ~coin.nickel & ~coin.dime;

   // Each bit depends only on its predecessor bits.
   always_comb begin
      nx[0] = q[0] & no_coin;
      nx[1] = (q[0] & coin.nickel) | (q[1] & no_coin);
      nx[2] = (q[0] & coin.dime) | (q[1] & coin.nickel) | (q[2] & no_coin);
      nx[3] = (q[1] & coin.dime) | (q[2] & coin.dime) | (q[2] & coin.nickel) | q[3];
   end

   always_ff @(posedge clk) begin
      if (rst) q <= IDLE_HOT;
      else     q <= nx;
   end

   assign credit    = credit_e'({q[3] | q[2], q[3] | q[1]});
   assign full_now  = q[3];
   assign full_next = ~rst & nx[3];

endmodule

// File: rtl/vend_release_stage.sv
module vend_release_stage #(
   parameter bit REG_OPEN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic full_now,
   input  logic full_next,
   output logic release_q
);

   generate
      if (REG_OPEN) begin : g_retimed
         // Next-state value of "full" is stored, so the pin is a flop output.
         always_ff @(posedge clk) begin
            if (rst) release_q <= 1'b0;
            else     release_q <= full_next;
         end
      end else begin : g_decoded
         logic unused_sig;
         assign unused_sig = ^{clk, rst, full_next};
         assign release_q  = full_now;
      end
   endgenerate

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
   import vend_pkg::*;
#(
   parameter enc_e ENC      = ENC_BINARY,
   parameter bit   REG_OPEN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic nickel_i,
   input  logic dime_i,
   output logic release_o
);

   coin_s   coin;
   credit_e credit;
   logic    full_now;
   logic    full_next;

   if (ENC != ENC_BINARY && ENC != ENC_ONEHOT) begin : g_bad_enc
      $error("coin_vend_ctrl: unsupported state encoding");
   end

   vend_coin_qual i_qual (
      .nickel_raw (nickel_i),
      .dime_raw   (dime_i),
      .coin       (coin)
   );

   generate
      if (ENC == ENC_ONEHOT) begin : g_onehot
         vend_state_onehot i_state (
            .clk       (clk),
            .rst       (rst),
            .coin      (coin),
            .credit    (credit),
            .full_now  (full_now),
            .full_next (full_next)
         );
      end else begin : g_binary
         vend_state_bin i_state (
            .clk       (clk),
            .rst       (rst),
            .coin      (coin),
            .credit    (credit),
            .full_now  (full_now),
            .full_next (full_next)
         );
      end
   endgenerate

   vend_release_stage #(.REG_OPEN(REG_OPEN)) i_rel (
      .clk       (clk),
      .rst       (rst),
      .full_now  (full_now),
      .full_next (full_next),
      .release_q (release_o)
   );

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
   import vend_pkg::*;
(
   input logic    clk,
   input logic    rst,
   input logic    nickel_i,
   input logic    dime_i,
   input logic    release_o,
   input credit_e credit
);

   AST_RESET_EMPTY: assert property (@(posedge clk)
      rst |=> (credit == CR_0 && !release_o)); // R1

   AST_NICKEL_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
      (nickel_i && !dime_i && credit == CR_0) |=> (credit == CR_5 && !release_o)); // R2

   AST_DIME_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
      (dime_i && credit == CR_0) |=> (credit == CR_10 && !release_o)); // R3

   AST_DIME_FROM_FIVE: assert property (@(posedge clk) disable iff (rst)
      (dime_i && credit == CR_5) |=> release_o); // R4

   AST_ANY_FROM_TEN: assert property (@(posedge clk) disable iff (rst)
      ((nickel_i || dime_i) && credit == CR_10) |=> release_o); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!nickel_i && !dime_i) |=> $stable(credit)); // R6

   AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (rst)
      release_o |=> release_o); // R7

   AST_PAIR_IS_DIME: assert property (@(posedge clk) disable iff (rst)
      (nickel_i && dime_i && credit == CR_0) |=> credit == CR_10); // R8

   AST_RELEASE_TRACKS_FULL: assert property (@(posedge clk) disable iff (rst)
      release_o == (credit == CR_15)); // R9

endmodule

bind coin_vend_ctrl vend_ctrl_chk i_chk (
   .clk       (clk),
   .rst       (rst),
   .nickel_i  (nickel_i),
   .dime_i    (dime_i),
   .release_o (release_o),
   .credit    (credit)
);

// File: tb/test_coin_vend_ctrl.sv
`timescale 1ns/1ps
module test_coin_vend_ctrl;
   import vend_pkg::*;

   localparam real HALF_NS    = 4.0;   // 125 MHz
   localparam int  MAX_CYCLES = 200000;
   localparam int  N_RANDOM   = 3000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       nickel = 1'b0;
   logic       dime = 1'b0;
   logic [3:0] rel;

   int n_checks = 0;
   int n_fails  = 0;
   int model    = 0;   // credit in 5-cent units, saturating at 3
   bit done     = 1'b0;

   always #(HALF_NS) clk = ~clk;

   // Four builds: {binary, one-hot} x {decoded, retimed}; all must agree (R9).
   coin_vend_ctrl #(.ENC(ENC_BINARY), .REG_OPEN(1'b0)) i_coin_vend_ctrl (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[0]));
   coin_vend_ctrl #(.ENC(ENC_ONEHOT), .REG_OPEN(1'b0)) i_coin_vend_ctrl_oh (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[1]));
   coin_vend_ctrl #(.ENC(ENC_BINARY), .REG_OPEN(1'b1)) i_coin_vend_ctrl_rb (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[2]));
   coin_vend_ctrl #(.ENC(ENC_ONEHOT), .REG_OPEN(1'b1)) i_coin_vend_ctrl_ro (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .release_o(rel[3]));

   function automatic int next_credit(int cur, bit r, bit n, bit d);
      if (r)      return 0;
      else if (d) return (cur + 2 > 3) ? 3 : cur + 2;
      else if (n) return (cur + 1 > 3) ? 3 : cur + 1;
      return cur;
   endfunction

   function automatic string req_of(int cur, bit r, bit n, bit d);
      if (r)           return "R1";
      if (n && d)      return "R8";
      if (cur == 3)    return "R7";
      if (!n && !d)    return "R6";
      if (cur == 0)    return d ? "R3" : "R2";
      if (cur == 1)    return "R4";
      return "R5";
   endfunction

   // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
   task automatic apply(bit r, bit n, bit d);
      string tag;
      logic [3:0] exp;
      tag    = req_of(model, r, n, d);
      rst    = r;
      nickel = n;
      dime   = d;
      @(posedge clk);
      model = next_credit(model, r, n, d);
      @(negedge clk);
      exp = {4{model == 3}};
      n_checks++;
      // R9: every build must show the same release value in this cycle
      if (rel !== exp) begin
         n_fails++;
         $display("FAIL %s (R9 builds bin/oh/rbin/roh): release got %b expected %b", tag, rel, exp);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      apply(1, 0, 0);                 // R1 reset state
      apply(1, 1, 1);                 // R1 reset wins over coins
      apply(0, 1, 0);                 // R2 0 -> 5
      apply(0, 0, 0);                 // R6 hold at 5
      apply(0, 1, 0);                 // R4 5 -> 10
      apply(0, 1, 0);                 // R5 10 -> 15
      apply(0, 1, 0);                 // R7 coin at full
      apply(0, 0, 1);                 // R7
      apply(0, 0, 0);                 // R7
      apply(1, 0, 0);                 // R1 clears release
      apply(0, 0, 1);                 // R3 0 -> 10
      apply(0, 0, 1);                 // R5 10 -> 15 by dime
      apply(1, 0, 0);
      apply(0, 1, 0);
      apply(0, 0, 1);                 // R4 5 -> 15 by dime
      apply(1, 0, 0);
      apply(0, 1, 1);                 // R8 pair from 0 -> 10, no release
      apply(0, 0, 0);                 // R6
      apply(0, 1, 1);                 // R8 10 -> 15
      apply(1, 0, 0);
      apply(0, 1, 0);
      apply(0, 1, 1);                 // R8 from 5: acts as dime -> 15
      for (int i = 0; i < N_RANDOM; i++) begin
         bit r, n, d;
         r = ($urandom % 16) == 0;
         n = ($urandom % 3) == 0;
         d = ($urandom % 4) == 0;
         apply(r, n, d);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: run hung, got no end, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule